// File: doc/BRIEF.md
# Flash Image Mailbox Target

This block is the target side of a register mailbox. A management agent reaches an on-chip image store through it, one 32-bit register access at a time. Every register sits at a dword offset from a configurable capability base. The agent fills a bank of sixteen data registers and then writes a command word. While the command runs, the block holds the command's request bit set. It then moves dwords between the data bank and the image store, records the outcome in a status register and clears the request bit. The agent polls the request bit to find out when the command has finished, and then reads the status.

The image store is modelled as an array of registers split into two equal regions. Flash reads draw from the region marked active. Flash writes land in the other region. An authenticate request swaps the roles of the two regions, but only when the first dword of the inactive region holds a configured image signature. A power-cycle request clears the data bank. A parameter sets the number of cycles that every command spends waiting before it runs, which stands in for the latency of a real storage operation.

Top module: `fmbox_target`

## Requirements
- R1: After reset, the data registers, the command register (offset 17) and the status register (offset 18) all read as zero. Reads take one cycle: the value for an address sampled with the read enable appears on the read-data port after that clock edge.
- R2: When no command is running, the data registers at offsets 1 to 16 accept writes and read back what was written. A read of any offset other than 1 to 18 returns zero.
- R3: Writing the command register with bit 0 set starts a command. Bit 0 reads as 1 for at least LATENCY cycles and then reads as 0. When it drops, the status register holds bit 29 set, the opcode in bits 7:4 and the outcome in bits 3:0.
- R4: Opcode 0x2 (flash read) copies dwords from the active region, starting at the dword address held in command bits 23:2, into the data registers starting at offset 1. The count field in bits 27:24 gives the number of dwords, and 0 means sixteen. Data registers past the count keep their values. The status outcome is 0.
- R5: Opcode 0x0 (flash write) copies the count field plus one dwords from the data registers into the inactive region. Flash reads do not return that data until a swap has taken place.
- R6: When command bit 1 is set on a flash write, the data goes to dword HDR_DWADDR, whatever the address field holds.
- R7: Opcode 0x1 (authenticate) swaps the two regions and reports outcome 0 if dword 0 of the inactive region equals IMG_MAGIC. Otherwise it reports outcome 1 and leaves both regions as they were.
- R8: A flash read or flash write whose start address plus dword count exceeds REGION_DWORDS reports outcome 2 and changes neither the data registers nor the array. An access that ends exactly at the end of the region succeeds.
- R9: Any opcode other than 0x0, 0x1, 0x2 and 0x4 completes with outcome 0xF.
- R10: While a command is running, writes to the command register and to the data registers have no effect.
- R11: Opcode 0x4 (power cycle) reports outcome 0 and sets all sixteen data registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register address; offsets are taken relative to CAP_BASE |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Registered read data, valid the cycle after regRdEn |

## Verification
The hardest case to reach is a command register write that arrives while an earlier command is still counting down its latency. From the ports, this case can only be seen in the opcode that ends up in the status register. The stimulus issues a short flash read and, on the very next cycle, writes a power-cycle command and a data register. It then checks that the status still names the read and that the data register kept its earlier value. A second case needs the inactive region to be seen through ports that only read the active region. The bench reaches it by running a failed authenticate, then a passing one, and then reading back the header and non-header addresses.

// File: rtl/fmbox_pkg.sv
package fmbox_pkg;
  localparam int SLOTS   = 16;
  localparam int SLOT_W  = 4;
  localparam int OFF_W   = 22;

  localparam int OFS_CMD  = 17;
  localparam int OFS_STAT = 18;

  localparam logic [3:0] OP_FWRITE = 4'h0;
  localparam logic [3:0] OP_AUTH   = 4'h1;
  localparam logic [3:0] OP_FREAD  = 4'h2;
  localparam logic [3:0] OP_PCYCLE = 4'h4;

  localparam logic [3:0] ST_OK     = 4'h0;
  localparam logic [3:0] ST_AUTH   = 4'h1;
  localparam logic [3:0] ST_ACCESS = 4'h2;
  localparam logic [3:0] ST_IOERR  = 4'hF;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER, S_FIN} mbox_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              latch;
    logic              step;
    logic              isWrite;
    logic [SLOT_W-1:0] slot;
    logic [OFF_W-1:0]  arrOff;
    logic              finish;
    logic              swap;
    logic              clrData;
    logic [3:0]        code;
    logic [3:0]        status;
  } mbox_strobe_t;
endpackage

// File: rtl/fmbox_ctrl.sv
module fmbox_ctrl
  import fmbox_pkg::*;
#(
  parameter int REGION_DWORDS = 64,
  parameter int HDR_DWADDR    = 48,
  parameter int LATENCY       = 4,
  parameter int ADDR_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regOff,
  input  logic [31:0]       regWrData,
  input  logic              imgValid,
  output logic              busy,
  output mbox_strobe_t      stb
);
  localparam int WAIT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [WAIT_W-1:0] WAIT_INIT = WAIT_W'(LATENCY - 1);
  localparam logic [OFF_W:0] REGION_LIM = (OFF_W+1)'(REGION_DWORDS);
  localparam int AGE_W = $clog2(LATENCY + 1) + 1;

  mbox_state_t       state;
  logic [3:0]        opcR;
  logic [4:0]        nR;
  logic [OFF_W-1:0]  baseR;
  logic [SLOT_W-1:0] idxR;
  logic [WAIT_W-1:0] waitCnt;
  logic              badR;
  logic              xferR;

  logic [3:0]        reqOp;
  logic [3:0]        reqCnt;
  logic [OFF_W-1:0]  reqAddr;
  logic              reqHdr;
  logic              hostCmdWr;
  logic              reqIsXfer;
  logic [4:0]        reqN;
  logic [OFF_W-1:0]  reqBase;
  logic [OFF_W:0]    reqEnd;
  logic              reqBad;

  // command word decode
  always_comb begin
    reqOp     = regWrData[31:28];
    reqCnt    = regWrData[27:24];
    reqAddr   = regWrData[23:2];
    reqHdr    = regWrData[1];
    hostCmdWr = regWrEn && (regOff == ADDR_W'(OFS_CMD)) && regWrData[0];
    reqIsXfer = (reqOp == OP_FREAD) || (reqOp == OP_FWRITE);
    if (reqOp == OP_FREAD)
      reqN = (reqCnt == 4'd0) ? 5'd16 : {1'b0, reqCnt};
    else
      reqN = {1'b0, reqCnt} + 5'd1;
    reqBase = ((reqOp == OP_FWRITE) && reqHdr) ? OFF_W'(HDR_DWADDR) : reqAddr;
    reqEnd  = {1'b0, reqBase} + {{(OFF_W-4){1'b0}}, reqN};
    reqBad  = reqIsXfer && (reqEnd > REGION_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      opcR    <= '0;
      nR      <= '0;
      baseR   <= '0;
      idxR    <= '0;
      waitCnt <= '0;
      badR    <= 1'b0;
      xferR   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (hostCmdWr) begin
          state   <= S_WAIT;
          opcR    <= reqOp;
          nR      <= reqN;
          baseR   <= reqBase;
          badR    <= reqBad;
          xferR   <= reqIsXfer;
          idxR    <= '0;
          waitCnt <= WAIT_INIT;
        end
        S_WAIT: begin
          if (waitCnt == '0)
            state <= (xferR && !badR) ? S_XFER : S_FIN;
          else
            waitCnt <= waitCnt - WAIT_W'(1);
        end
        S_XFER: begin
          if ({1'b0, idxR} == nR - 5'd1) state <= S_FIN;
          else idxR <= idxR + SLOT_W'(1);
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    stb         = '0;
    stb.latch   = (state == S_IDLE) && hostCmdWr;
    stb.step    = (state == S_XFER);
    stb.isWrite = (opcR == OP_FWRITE);
    stb.slot    = idxR;
    stb.arrOff  = baseR + OFF_W'(idxR);
    stb.finish  = (state == S_FIN);
    stb.code    = opcR;
    if (badR) stb.status = ST_ACCESS;
    else begin
      case (opcR)
        OP_FWRITE, OP_FREAD, OP_PCYCLE: stb.status = ST_OK;
        OP_AUTH: stb.status = imgValid ? ST_OK : ST_AUTH;
        default: stb.status = ST_IOERR;
      endcase
    end
    stb.swap    = stb.finish && (opcR == OP_AUTH) && imgValid && !badR;
    stb.clrData = stb.finish && (opcR == OP_PCYCLE);
  end

  // cycles spent busy since the last accepted command
  logic [AGE_W-1:0] ageCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ageCnt <= '0;
    else if (stb.latch) ageCnt <= '0;
    else if (busy && (ageCnt < AGE_W'(LATENCY))) ageCnt <= ageCnt + AGE_W'(1);
  end

  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ageCnt == AGE_W'(LATENCY)));

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.latch, stb.step, stb.finish}));

  p_cmd_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hostCmdWr) |=> ($stable(opcR) && $stable(baseR)));

  p_step_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stb.step |-> ({1'b0, stb.arrOff} < REGION_LIM));
endmodule

// File: rtl/fmbox_dpath.sv
module fmbox_dpath
  import fmbox_pkg::*;
#(
  parameter int          REGION_DWORDS = 64,
  parameter int          ADDR_W        = 8,
  parameter logic [31:0] IMG_MAGIC     = 32'h5AFE1A6E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regOff,
  input  logic [31:0]       regWrData,
  input  logic              busy,
  input  mbox_strobe_t      stb,
  output logic              imgValid,
  output logic [31:0]       regRdData
);
  localparam int AW    = $clog2(REGION_DWORDS);
  localparam int DEPTH = 2 * REGION_DWORDS;

  logic [31:0]            store [DEPTH];
  logic [SLOTS-1:0][31:0] mbox;
  logic [31:1]            cmdReg;
  logic [31:0]            statReg;
  logic                   activeSel;

  logic [AW-1:0] arrIdx;
  logic          unusedOffBits;
  logic [AW:0]   rdPhys;
  logic [AW:0]   wrPhys;
  logic          isDataOff;
  logic          hostDataWr;
  logic [SLOT_W-1:0] dataSlot;

  assign arrIdx        = stb.arrOff[AW-1:0];
  assign unusedOffBits = ^stb.arrOff[OFF_W-1:AW];
  assign rdPhys        = {activeSel, arrIdx};
  assign wrPhys        = {~activeSel, arrIdx};
  assign imgValid      = (store[{~activeSel, {AW{1'b0}}}] == IMG_MAGIC);
  assign isDataOff     = (regOff >= ADDR_W'(1)) && (regOff <= ADDR_W'(SLOTS));
  assign hostDataWr    = regWrEn && !busy && isDataOff;
  assign dataSlot      = SLOT_W'(regOff - ADDR_W'(1));

  // image store with active/inactive regions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      activeSel <= 1'b0;
    end else begin
      if (stb.step && stb.isWrite) store[wrPhys] <= mbox[stb.slot];
      if (stb.swap) activeSel <= ~activeSel;
    end
  end

  // data bank
  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mbox[s] <= '0;
        else if (stb.clrData) mbox[s] <= '0;
        else if (stb.step && !stb.isWrite && (stb.slot == SLOT_W'(s)))
          mbox[s] <= store[rdPhys];
        else if (hostDataWr && (dataSlot == SLOT_W'(s)))
          mbox[s] <= regWrData;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg  <= '0;
      statReg <= '0;
    end else begin
      if (stb.latch) cmdReg <= regWrData[31:1];
      if (stb.finish) statReg <= {2'b00, 1'b1, 21'd0, stb.code, stb.status};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regRdData <= '0;
    else if (regRdEn) begin
      if (isDataOff)                         regRdData <= mbox[dataSlot];
      else if (regOff == ADDR_W'(OFS_CMD))   regRdData <= {cmdReg, busy};
      else if (regOff == ADDR_W'(OFS_STAT))  regRdData <= statReg;
      else                                   regRdData <= '0;
    end
  end

  p_done_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> statReg[29]);

  p_swap_auth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(activeSel) |-> (($past(stb.code) == OP_AUTH) && (statReg[3:0] == ST_OK)));

  p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && regWrEn && !stb.step && !stb.clrData) |=> $stable(mbox));
endmodule

// File: rtl/fmbox_target.sv
module fmbox_target
  import fmbox_pkg::*;
#(
  parameter int          ADDR_W        = 8,
  parameter int          CAP_BASE      = 64,
  parameter int          REGION_DWORDS = 64,
  parameter int          HDR_DWADDR    = 48,
  parameter int          LATENCY       = 4,
  parameter logic [31:0] IMG_MAGIC     = 32'h5AFE1A6E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData
);
  logic [ADDR_W-1:0] regOff;
  logic              busy;
  logic              imgValid;
  mbox_strobe_t      stb;

  assign regOff = regAddr - ADDR_W'(CAP_BASE);

  fmbox_ctrl #(
    .REGION_DWORDS(REGION_DWORDS),
    .HDR_DWADDR   (HDR_DWADDR),
    .LATENCY      (LATENCY),
    .ADDR_W       (ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .regWrEn  (regWrEn),
    .regOff   (regOff),
    .regWrData(regWrData),
    .imgValid (imgValid),
    .busy     (busy),
    .stb      (stb)
  );

  fmbox_dpath #(
    .REGION_DWORDS(REGION_DWORDS),
    .ADDR_W       (ADDR_W),
    .IMG_MAGIC    (IMG_MAGIC)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regOff   (regOff),
    .regWrData(regWrData),
    .busy     (busy),
    .stb      (stb),
    .imgValid (imgValid),
    .regRdData(regRdData)
  );
endmodule

// File: tb/fmbox_target_bench.sv
`timescale 1ns/1ps
module fmbox_target_bench;
  localparam int          ADDR_W = 8;
  localparam int          CAP    = 64;
  localparam int          REGION = 64;
  localparam int          HDR    = 48;
  localparam int          LAT    = 4;
  localparam logic [31:0] MAGIC  = 32'h5AFE1A6E;
  localparam int          OCMD   = 17;
  localparam int          OSTAT  = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWrEn = 1'b0;
  logic regRdEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  always #2.5 clk = ~clk;

  fmbox_target #(
    .ADDR_W(ADDR_W), .CAP_BASE(CAP), .REGION_DWORDS(REGION),
    .HDR_DWADDR(HDR), .LATENCY(LAT), .IMG_MAGIC(MAGIC)
  ) u_fmbox_target (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  typedef struct {
    logic [31:0] exp;
    bit          chk;
    string       tag;
  } rd_item_t;

  rd_item_t    rdQ[$];
  logic        rdSeen = 1'b0;
  logic [31:0] lastRd = '0;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  // monitor: pop expected item per completed read
  always @(posedge clk) rdSeen <= regRdEn;
  always @(negedge clk) begin
    if (rdSeen && rdQ.size() > 0) begin
      rd_item_t it;
      it = rdQ.pop_front();
      lastRd = regRdData;
      if (it.chk) begin
        nChecks++;
        if (regRdData !== it.exp) begin
          nFails++;
          $display("FAIL %s act=%h exp=%h", it.tag, regRdData, it.exp);
        end
      end
    end
  end

  function automatic logic [31:0] mkCmd(logic [3:0] op, logic [3:0] cnt, int addr, bit hdr);
    logic [21:0] a;
    a = 22'(addr);
    return {op, cnt, a, hdr, 1'b1};
  endfunction

  function automatic logic [31:0] pat(int i, int seed);
    return 32'hA5000000 ^ (32'(seed) << 8) ^ 32'(i);
  endfunction

  function automatic logic [31:0] stw(logic [3:0] code, logic [3:0] st);
    return {2'b00, 1'b1, 21'd0, code, st};
  endfunction

  task automatic regWrite(int off, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = ADDR_W'(CAP + off); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(int off, logic [31:0] exp, bit chk, string tag);
    rd_item_t it;
    @(negedge clk);
    regRdEn = 1'b1; regAddr = ADDR_W'(CAP + off);
    it.exp = exp; it.chk = chk; it.tag = tag;
    rdQ.push_back(it);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // issue a command and poll the request bit until it drops
  task automatic runCmd(logic [31:0] cmd, output int cyc, output bit firstBusy);
    regWrite(OCMD, cmd);
    cyc = 0;
    firstBusy = 1'b0;
    for (int p = 0; p < 200; p++) begin
      regRead(OCMD, 32'h0, 1'b0, "");
      @(posedge clk);
      #1;
      cyc += 2;
      if (p == 0) firstBusy = lastRd[0];
      if (!lastRd[0]) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int  cyc;
    bit  fb;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    regRead(OSTAT, 32'h0, 1'b1, "R1 status");
    regRead(OCMD,  32'h0, 1'b1, "R1 cmd");
    regRead(1,     32'h0, 1'b1, "R1 data1");

    // R2 data bank write/readback, unmapped offsets
    for (int k = 1; k <= 16; k++) regWrite(k, (k == 1) ? MAGIC : pat(k, 1));
    regRead(1,  MAGIC,     1'b1, "R2 data1");
    regRead(16, pat(16,1), 1'b1, "R2 data16");
    regRead(0,  32'h0,     1'b1, "R2 off0");
    regRead(19, 32'h0,     1'b1, "R2 off19");

    // R3/R5 sixteen-dword flash write into the inactive region
    runCmd(mkCmd(4'h0, 4'd15, 0, 1'b0), cyc, fb);
    check(fb == 1'b1, "R3 request bit set while running", int'(fb), 1);
    check(cyc >= LAT, "R3 minimum busy cycles", cyc, LAT);
    regRead(OSTAT, stw(4'h0, 4'h0), 1'b1, "R3 R5 write status");

    // R4/R5 full read (count 0) sees the still-empty active region
    runCmd(mkCmd(4'h2, 4'd0, 0, 1'b0), cyc, fb);
    regRead(OSTAT, stw(4'h2, 4'h0), 1'b1, "R4 read status");
    for (int k = 1; k <= 16; k++) regRead(k, 32'h0, 1'b1, "R5 write not visible before swap");

    // R7 authenticate with valid signature
    runCmd(mkCmd(4'h1, 4'd0, 0, 1'b0), cyc, fb);
    regRead(OSTAT, stw(4'h1, 4'h0), 1'b1, "R7 auth ok");

    // R4 partial read leaves upper slots
    for (int k = 1; k <= 16; k++) regWrite(k, 32'hDEAD0000 | 32'(k));
    runCmd(mkCmd(4'h2, 4'd3, 0, 1'b0), cyc, fb);
    regRead(1, MAGIC,        1'b1, "R4 dword0");
    regRead(2, pat(2, 1),    1'b1, "R4 dword1");
    regRead(3, pat(3, 1),    1'b1, "R4 dword2");
    regRead(4, 32'hDEAD0004, 1'b1, "R4 slot beyond count kept");

    // R6 header write to fixed address
    regWrite(1, pat(1, 2));
    regWrite(2, pat(2, 2));
    runCmd(mkCmd(4'h0, 4'd1, 5, 1'b1), cyc, fb);
    regRead(OSTAT, stw(4'h0, 4'h0), 1'b1, "R6 header write status");

    // R7 authenticate fails: inactive dword0 empty
    runCmd(mkCmd(4'h1, 4'd0, 0, 1'b0), cyc, fb);
    regRead(OSTAT, stw(4'h1, 4'h1), 1'b1, "R7 auth error");
    runCmd(mkCmd(4'h2, 4'd1, 0, 1'b0), cyc, fb);
    regRead(1, MAGIC, 1'b1, "R7 no swap on failure");

    // place signature, swap, then inspect header location
    regWrite(1, MAGIC);
    runCmd(mkCmd(4'h0, 4'd0, 0, 1'b0), cyc, fb);
    runCmd(mkCmd(4'h1, 4'd0, 0, 1'b0), cyc, fb);
    regRead(OSTAT, stw(4'h1, 4'h0), 1'b1, "R7 auth ok second");
    runCmd(mkCmd(4'h2, 4'd2, HDR, 1'b0), cyc, fb);
    regRead(1, pat(1, 2), 1'b1, "R6 header dword0");
    regRead(2, pat(2, 2), 1'b1, "R6 header dword1");
    runCmd(mkCmd(4'h2, 4'd2, 5, 1'b0), cyc, fb);
    regRead(1, 32'h0, 1'b1, "R6 address field unused");

    // R8 range handling
    regWrite(1, 32'h11111111);
    runCmd(mkCmd(4'h2, 4'd4, REGION - 2, 1'b0), cyc, fb);
    regRead(OSTAT, stw(4'h2, 4'h2), 1'b1, "R8 read overrun status");
    regRead(1, 32'h11111111, 1'b1, "R8 data kept on overrun");
    runCmd(mkCmd(4'h2, 4'd4, REGION - 4, 1'b0), cyc, fb);
    regRead(OSTAT, stw(4'h2, 4'h0), 1'b1, "R8 exact end ok");
    regRead(1, 32'h0, 1'b1, "R8 exact end data");
    runCmd(mkCmd(4'h0, 4'd1, REGION - 1, 1'b0), cyc, fb);
    regRead(OSTAT, stw(4'h0, 4'h2), 1'b1, "R8 write overrun status");

    // R9 unknown opcode
    runCmd(mkCmd(4'h7, 4'd0, 0, 1'b0), cyc, fb);
    regRead(OSTAT, stw(4'h7, 4'hF), 1'b1, "R9 io error");

    // R10 writes during a running command
    regWrite(10, 32'h0A0A0A0A);
    regWrite(OCMD, mkCmd(4'h2, 4'd1, HDR, 1'b0));
    regWrite(OCMD, mkCmd(4'h4, 4'd0, 0, 1'b0));
    regWrite(10, 32'hBBBBBBBB);
    runCmd(32'h0, cyc, fb);
    regRead(OSTAT, stw(4'h2, 4'h0), 1'b1, "R10 second command ignored");
    regRead(10, 32'h0A0A0A0A, 1'b1, "R10 data write ignored");
    regRead(1, pat(1, 2), 1'b1, "R10 first command ran");

    // R11 power cycle
    runCmd(mkCmd(4'h4, 4'd0, 0, 1'b0), cyc, fb);
    regRead(OSTAT, stw(4'h4, 4'h0), 1'b1, "R11 status");
    regRead(1,  32'h0, 1'b1, "R11 data1 cleared");
    regRead(10, 32'h0, 1'b1, "R11 data10 cleared");

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule